// File: doc/BRIEF.md
# Serial Character Receiver with Start Filtering

This block takes a single asynchronous serial line, as used by contact smart cards, and turns each incoming character into a byte for a host. A character is one low start bit, eight data bits, one parity bit and one or two high stop bits. The length of one bit is given at run time as a count of system clocks, and it must be at least 4. The bit order and the parity sense are chosen by inputs. These inputs, and the stop-bit count, must stay stable while a character is being received.

After a falling edge the receiver samples the line again half a bit later. If the line is high by then, it treats the low level as a glitch and goes back to idle. Once the start bit is confirmed, it samples every later bit at its middle. It reports its phase on three outputs: tentative start, confirmed reception, and stop bits. At the close of the last stop bit it gives a one-cycle pulse and sets exactly one outcome flag. The outcome is data ready, overrun or frame error. The host clears the flags with an acknowledge pulse.

Top module: `sc_char_rx`

## Requirements
- R1: With `two_stop`=0 a character spans 11 bit periods (start, 8 data, parity, 1 stop). With `two_stop`=1 it spans 12. The end pulse comes within a few clocks after the last stop bit period ends on the line.
- R2: With `odd_par`=1, the eight data bits plus the parity bit must hold an odd number of ones. With `odd_par`=0 they must hold an even number. A character that meets this is accepted.
- R3: With `msb_first`=1 the first data bit after the start bit is bit 7 of `data_out`. With `msb_first`=0 it is bit 0.
- R4: A wrong parity bit, or any stop bit sampled low, sets `frame_err_flag`. In that case `ready_flag` is not newly set and `data_out` keeps its value.
- R5: When a good character completes while `ready_flag` is still set and no acknowledge arrives in that cycle, `overrun_flag` sets and `data_out` keeps the earlier byte.
- R6: `end_pulse` is high for exactly one clock per received character.
- R7: A low level on the line that ends before half a bit period raises `start_phase` for a while. It never raises `rx_run` and never sets any flag.
- R8: `rx_run` is high from the confirmed start to the end pulse. `stop_phase` is high during the stop bits. After the end pulse, at least one outcome flag is set, and the flag for this character is set.
- R9: An `flag_ack` pulse clears the three flags. If a character completes in the same cycle, its outcome is set anyway, and the acknowledged old byte does not count as unread.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| bit_clocks | input | CPB_W | System clocks per bit, at least 4 |
| two_stop | input | 1 | 1: two stop bits |
| odd_par | input | 1 | 1: odd parity, 0: even parity |
| msb_first | input | 1 | 1: data bit 7 arrives first |
| flag_ack | input | 1 | Clears ready, overrun and frame-error flags |
| data_out | output | 8 | Last accepted byte |
| ready_flag | output | 1 | A new byte is waiting |
| overrun_flag | output | 1 | A byte arrived while the previous one was unread |
| frame_err_flag | output | 1 | Parity or stop bit error |
| end_pulse | output | 1 | One-cycle pulse at the end of the last stop bit |
| rx_run | output | 1 | Reception confirmed and in progress |
| start_phase | output | 1 | Start detected, not yet confirmed |
| stop_phase | output | 1 | Receiving stop bits |

## Verification
The bench sends a three-clock glitch. A receiver that does not re-check at mid start bit would frame garbage and raise a flag. It measures the time from the start edge to the end pulse under both stop-bit settings. A receiver that ignores the second stop bit would finish one full bit early. It corrupts only the second stop bit, which a receiver that checks just the first would miss. It also sends a second byte without an acknowledge, and sends another with the acknowledge landing in the end-pulse cycle. These catch a receiver that overwrites unread data, and one that lets the clear beat the new flag.

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int CPB_W = 13,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [CPB_W-1:0] bit_clocks,
  input  logic             two_stop,
  input  logic             odd_par,
  input  logic             msb_first,
  input  logic             flag_ack,
  output logic [NBITS-1:0] data_out,
  output logic             ready_flag,
  output logic             overrun_flag,
  output logic             frame_err_flag,
  output logic             end_pulse,
  output logic             rx_run,
  output logic             start_phase,
  output logic             stop_phase
);

  localparam int IDX_W = $clog2(NBITS + 3);
  localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(NBITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_TAIL} state_t;

  state_t           state;
  logic             sy1, sy2;
  logic [CPB_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] shreg;
  logic             err;

  wire [CPB_W-1:0] half     = bit_clocks >> 1;
  wire [IDX_W-1:0] last_idx = two_stop ? IDX_W'(NBITS + 2) : IDX_W'(NBITS + 1);
  wire confirm  = (state == S_START) && (cnt == half - 1'b1);
  wire sample   = (state == S_BITS) && (cnt == bit_clocks - 1'b1);
  wire finish   = (state == S_TAIL) && (cnt == bit_clocks - half - 1'b1);
  wire par_bad  = ((^shreg) ^ sy2) != odd_par;

  assign end_pulse   = finish;
  assign start_phase = (state == S_START);
  assign rx_run      = (state == S_BITS) || (state == S_TAIL);
  assign stop_phase  = ((state == S_BITS) && (idx > PAR_IDX)) || (state == S_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1;
      sy2 <= 1'b1;
    end else begin
      sy1 <= rx_line;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          idx <= '0;
          err <= 1'b0;
          if (!sy2) state <= S_START;
        end
        S_START: begin
          if (confirm) begin
            cnt   <= '0;
            state <= sy2 ? S_IDLE : S_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BITS: begin
          if (sample) begin
            cnt <= '0;
            if (idx < PAR_IDX)
              shreg <= msb_first ? {shreg[NBITS-2:0], sy2} : {sy2, shreg[NBITS-1:1]};
            else if (idx == PAR_IDX) begin
              if (par_bad) err <= 1'b1;
            end else if (!sy2)
              err <= 1'b1;
            if (idx == last_idx) state <= S_TAIL;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (finish) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out       <= '0;
      ready_flag     <= 1'b0;
      overrun_flag   <= 1'b0;
      frame_err_flag <= 1'b0;
    end else begin
      if (flag_ack) begin
        ready_flag     <= 1'b0;
        overrun_flag   <= 1'b0;
        frame_err_flag <= 1'b0;
      end
      if (finish) begin
        if (err)
          frame_err_flag <= 1'b1;
        else if (ready_flag && !flag_ack)
          overrun_flag <= 1'b1;
        else begin
          ready_flag <= 1'b1;
          data_out   <= shreg;
        end
      end
    end
  end

  assert_end_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse);
  assert_outcome_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> (ready_flag || overrun_flag || frame_err_flag));
  assert_run_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_run) |-> $past(start_phase));
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ack && !end_pulse) |=> !(ready_flag || overrun_flag || frame_err_flag));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !end_pulse |=> $stable(data_out));

endmodule

// File: tb/sc_char_rx_bench.sv
module sc_char_rx_bench;
  localparam int CPB_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic [CPB_W-1:0] bit_clocks = 13'd16;
  logic two_stop = 1'b0, odd_par = 1'b0, msb_first = 1'b0, flag_ack = 1'b0;
  logic [7:0] data_out;
  logic ready_flag, overrun_flag, frame_err_flag, end_pulse, rx_run, start_phase, stop_phase;

  sc_char_rx #(.CPB_W(CPB_W), .NBITS(8)) u_sc_char_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_clocks(bit_clocks),
    .two_stop(two_stop), .odd_par(odd_par), .msb_first(msb_first), .flag_ack(flag_ack),
    .data_out(data_out), .ready_flag(ready_flag), .overrun_flag(overrun_flag),
    .frame_err_flag(frame_err_flag), .end_pulse(end_pulse), .rx_run(rx_run),
    .start_phase(start_phase), .stop_phase(stop_phase));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int end_cnt, end_at, t0;
  bit seen_run, seen_stop, seen_start, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (end_pulse) begin
      if (end_cnt == 0) end_at = cyc;
      end_cnt++;
    end
    if (rx_run) seen_run = 1;
    if (stop_phase) seen_stop = 1;
    if (start_phase) seen_start = 1;
  end

  // fields: [12:5] byte, [4] msb_first, [3] odd_par, [2] two_stop, [1] bad parity, [0] bad last stop
  localparam logic [12:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit msb, input bit odd, input bit two,
                      input bit badp, input bit bads);
    int p = int'(bit_clocks);
    msb_first = msb; odd_par = odd; two_stop = two;
    end_cnt = 0; seen_run = 0; seen_stop = 0; seen_start = 0;
    @(negedge clk);
    t0 = cyc;
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(msb ? b[7-i] : b[i], p);
    hold((^b) ^ odd ^ badp, p);
    hold(!(bads && !two), p);
    if (two) hold(!bads, p);
    hold(1'b1, 3 * p);
  endtask

  task automatic frame_timing(input bit two, input string tag);
    int span = (two ? 12 : 11) * int'(bit_clocks);
    chk(end_cnt == 1, {tag, " R6 pulse count"}, end_cnt, 1);
    chk(end_at - t0 >= span && end_at - t0 <= span + 5, {tag, " R1 end timing"}, end_at - t0, span + 2);
    chk(seen_run && seen_stop, {tag, " R8 phases"}, {seen_run, seen_stop}, 3);
  endtask

  task automatic ack();
    flag_ack = 1'b1; @(negedge clk); flag_ack = 1'b0; @(negedge clk);
  endtask

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    chk({data_out, ready_flag, overrun_flag, frame_err_flag, end_pulse, rx_run, start_phase, stop_phase} == 0,
        "R10 reset", {data_out, ready_flag, overrun_flag, frame_err_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    prev = 8'h00;
    foreach (VEC[k]) begin
      logic [12:0] v = VEC[k];
      bit fe = v[1] | v[0];
      send(v[12:5], v[4], v[3], v[2], v[1], v[0]);
      frame_timing(v[2], "table");
      chk(frame_err_flag == fe, "R4 R2 frame flag", frame_err_flag, fe);
      chk(ready_flag == !fe, "R2 ready flag", ready_flag, !fe);
      chk(data_out == (fe ? prev : v[12:5]), "R3 R4 data", data_out, fe ? prev : v[12:5]);
      if (!fe) prev = v[12:5];
      ack();
      chk({ready_flag, overrun_flag, frame_err_flag} == 0, "R9 ack clears", {ready_flag, overrun_flag, frame_err_flag}, 0);
    end

    // glitch shorter than half a bit
    end_cnt = 0; seen_run = 0; seen_start = 0;
    hold(1'b0, 3);
    hold(1'b1, 40);
    chk(seen_start, "R7 start seen", seen_start, 1);
    chk(!seen_run && end_cnt == 0, "R7 no run", {seen_run, end_cnt[0]}, 0);
    chk({ready_flag, overrun_flag, frame_err_flag} == 0, "R7 no flags", {ready_flag, overrun_flag, frame_err_flag}, 0);
    send(8'h96, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(data_out == 8'h96 && ready_flag, "R7 after glitch", data_out, 8'h96);

    // overrun: previous byte unread
    send(8'h4D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(overrun_flag == 1'b1, "R5 overrun", overrun_flag, 1);
    chk(data_out == 8'h96, "R5 data kept", data_out, 8'h96);
    chk(ready_flag && !frame_err_flag, "R5 other flags", {ready_flag, frame_err_flag}, 2);
    ack();

    // ack in the end-pulse cycle, with old byte still unread
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    fork
      send(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      begin
        @(negedge clk);
        while (!end_pulse) @(negedge clk);
        flag_ack = 1'b1; @(negedge clk); flag_ack = 1'b0;
      end
    join
    chk(ready_flag && !overrun_flag, "R9 same-cycle ack", {ready_flag, overrun_flag}, 2);
    chk(data_out == 8'h22, "R9 new data", data_out, 8'h22);
    ack();

    // odd bit period and default smart-card rate
    bit_clocks = 13'd15;
    send(8'h6E, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    frame_timing(1'b1, "odd period");
    chk(data_out == 8'h6E && ready_flag, "R3 odd period data", data_out, 8'h6E);
    ack();
    bit_clocks = 13'd372;
    send(8'hB2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    frame_timing(1'b1, "372");
    chk(data_out == 8'hB2 && ready_flag, "R1 372 data", data_out, 8'hB2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule